// File: doc/BRIEF.md
# Adjustable PTP Time-of-Day Clock

This block keeps the time of day for a precision time protocol node as a 32-bit seconds count and a 30-bit nanoseconds count that rolls over at one billion. Each clock cycle it advances by a nominal number of nanoseconds. A signed frequency trim, held as a magnitude and a direction, feeds a fractional accumulator; every accumulator overflow lengthens or shortens one tick by a single nanosecond.

Software reaches the block through a synchronous 16-bit register port with banked addressing. One register at a fixed address picks the bank. On the clock bank a command register starts or stops the counter, loads an absolute time, steps the time by a signed offset, or takes a snapshot. A single time data register carries the four 16-bit time words, both when a time is staged for load or step and when a snapshot is read back. Two further registers hold the trim magnitude and its direction.

Top module: `ptod_clock`

## Requirements
- R1: After reset the time is zero seconds and zero nanoseconds, the counter is stopped, the bank select is 0, the trim is zero and the read data output is 0.
- R2: The bank select register sits at address 0x13 and can be written and read on every bank. The command (0x14), time data (0x15), trim-high (0x16) and trim-low (0x17) registers act only while the bank select holds 4. On any other bank, writes to those addresses have no effect and reads return 0.
- R3: Consecutive writes to the time data register stage four words: nanoseconds[15:0], then nanoseconds[29:16] in bits 13:0 (bits 15:14 ignored), then seconds[15:0], then seconds[31:16]. Command bit 2 (load) replaces the time with the staged value on the edge of the command write, and that edge adds no tick.
- R4: Command bit 0 starts the counter and bit 1 stops it; stop wins when both are set. While running, the time grows by NOM_INC nanoseconds (8 by default) on every edge, starting with the edge after the start command, and the edge that takes a stop command still ticks. Load (bit 2) wins over step (bit 3).
- R5: The nanoseconds count never reaches 1,000,000,000; when a tick or a step carries it past that value it wraps and the seconds count rises by one.
- R6: Command bit 3 (step) adds the staged value as an offset, seconds in two's complement and nanoseconds in 0..999,999,999, on top of the tick of that edge. A negative offset is written as seconds -1 with nanoseconds 10^9 minus the magnitude; it borrows from the seconds when the nanoseconds would fall below zero.
- R7: Command bit 4 (snapshot) captures the time shown during the cycle of the command write. Four subsequent reads of the time data register return the captured words in the staging order, with bits 15:14 of the second word as 0. Read data appears on the cycle after the read strobe.
- R8: The trim magnitude is trim-high bits 9:0 followed by trim-low bits 15:0; trim-high bit 15 marks a negative trim, and trim-high bits 14:10 are dropped and read back as 0. Each running cycle adds the magnitude to a 32-bit accumulator; on an edge where it overflows, the tick is NOM_INC+1, or NOM_INC-1 for a negative trim. A zero magnitude gives exactly NOM_INC per edge.
- R9: Any write to the command register, even with no command bits set, returns both the staging index and the readback index to the first word.
- R10: A staged nanoseconds value from 1,000,000,000 up to 2^30-1 is reduced by 10^9 and carries one second into the loaded or stepped time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after bus_rd |
| tod_sec | output | 32 | Current seconds |
| tod_ns | output | 30 | Current nanoseconds |
| tod_running | output | 1 | Counter is running |

## Verification
The risky overlap is a step or snapshot command landing on an edge where the running counter also ticks, possibly with a trim carry on that same edge. The bench provokes this by issuing step and snapshot commands while the counter runs with a nonzero trim, and it places steps so that the tick plus the offset crosses a second boundary in both directions. It judges the result by holding the expected time as one 64-bit nanosecond total. The tick, the trim carry and the offset are summed into that total, and the expected seconds and nanoseconds are then split out of it. This gives a different arithmetic path from the RTL's folded per-field carries.

// File: rtl/ptod_pkg.sv
package ptod_pkg;

  localparam int unsigned NS_PER_SEC = 32'd1_000_000_000;

  // register addresses; the bank select address is fixed by the bus contract
  localparam int A_BANK   = 8'h13;
  localparam int A_CMD    = 8'h14;
  localparam int A_TDATA  = 8'h15;
  localparam int A_TRIMHI = 8'h16;
  localparam int A_TRIMLO = 8'h17;

  // command bit positions
  localparam int CB_START = 0;
  localparam int CB_STOP  = 1;
  localparam int CB_LOAD  = 2;
  localparam int CB_STEP  = 3;
  localparam int CB_SNAP  = 4;

  localparam int TRIM_DIR_BIT = 15;

  typedef struct packed {
    logic snap;
    logic step;
    logic load;
    logic stop;
    logic start;
  } cmd_t;

  typedef struct packed {
    logic        carry;
    logic [29:0] ns;
  } ns_fold_t;

  // fold a raw nanosecond sum below one second (raw < 2 * NS_PER_SEC)
  function automatic ns_fold_t fold_ns(input logic [31:0] raw);
    ns_fold_t r;
    if (raw >= NS_PER_SEC) begin
      r.carry = 1'b1;
      r.ns    = 30'(raw - NS_PER_SEC);
    end else begin
      r.carry = 1'b0;
      r.ns    = 30'(raw);
    end
    return r;
  endfunction

  function automatic cmd_t decode_cmd(input logic [15:0] w);
    cmd_t c;
    c.start = w[CB_START];
    c.stop  = w[CB_STOP];
    c.load  = w[CB_LOAD];
    c.step  = w[CB_STEP];
    c.snap  = w[CB_SNAP];
    return c;
  endfunction

  // one of the four 16-bit time words, in transfer order
  function automatic logic [15:0] time_word(input logic [1:0] idx,
                                            input logic [31:0] sec,
                                            input logic [29:0] ns);
    case (idx)
      2'd0:    return ns[15:0];
      2'd1:    return {2'b00, ns[29:16]};
      2'd2:    return sec[15:0];
      default: return sec[31:16];
    endcase
  endfunction

endpackage

// File: rtl/ptod_regif.sv
module ptod_regif
  import ptod_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int BANK_W   = 3,
  parameter int CLK_BANK = 4,
  parameter int RATE_W   = 26
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  input  logic [31:0]       cur_sec,
  input  logic [29:0]       cur_ns,
  output cmd_t              cmd,
  output logic [31:0]       stage_sec,
  output logic [29:0]       stage_ns,
  output logic [RATE_W-1:0] rate_mag,
  output logic              rate_neg,
  output logic [1:0]        wr_idx,
  output logic [15:0]       bus_rdata
);

  localparam int          HI_BITS = RATE_W - 16;
  localparam logic [15:0] HI_MASK = 16'((1 << HI_BITS) - 1) | (16'd1 << TRIM_DIR_BIT);
  localparam int          WORDS   = 4;

  logic [BANK_W-1:0] bank_q;
  logic [15:0]       stage_q [WORDS];
  logic [15:0]       snap_q  [WORDS];
  logic [1:0]        wr_idx_q, rd_idx_q;
  logic [15:0]       trim_hi_q, trim_lo_q, rdata_q, rd_mux;

  logic on_bank, hit_bank, hit_cmd, hit_data, hit_thi, hit_tlo;

  assign on_bank  = bank_q == BANK_W'(CLK_BANK);
  assign hit_bank = bus_addr == ADDR_W'(A_BANK);
  assign hit_cmd  = on_bank && bus_addr == ADDR_W'(A_CMD);
  assign hit_data = on_bank && bus_addr == ADDR_W'(A_TDATA);
  assign hit_thi  = on_bank && bus_addr == ADDR_W'(A_TRIMHI);
  assign hit_tlo  = on_bank && bus_addr == ADDR_W'(A_TRIMLO);

  assign cmd = (bus_wr && hit_cmd) ? decode_cmd(bus_wdata) : '0;

  always_comb begin
    rd_mux = '0;
    if (hit_bank)      rd_mux = 16'(bank_q);
    else if (hit_data) rd_mux = snap_q[rd_idx_q];
    else if (hit_thi)  rd_mux = trim_hi_q;
    else if (hit_tlo)  rd_mux = trim_lo_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q    <= '0;
      wr_idx_q  <= '0;
      rd_idx_q  <= '0;
      trim_hi_q <= '0;
      trim_lo_q <= '0;
      rdata_q   <= '0;
      for (int i = 0; i < WORDS; i++) begin
        stage_q[i] <= '0;
        snap_q[i]  <= '0;
      end
    end else begin
      if (bus_wr) begin
        if (hit_bank) bank_q <= bus_wdata[BANK_W-1:0];
        if (hit_data) begin
          stage_q[wr_idx_q] <= bus_wdata;
          wr_idx_q          <= wr_idx_q + 2'd1;
        end
        if (hit_cmd) begin
          wr_idx_q <= '0;
          rd_idx_q <= '0;
          if (cmd.snap)
            for (int i = 0; i < WORDS; i++) snap_q[i] <= time_word(2'(i), cur_sec, cur_ns);
        end
        if (hit_thi) trim_hi_q <= bus_wdata & HI_MASK;
        if (hit_tlo) trim_lo_q <= bus_wdata;
      end
      if (bus_rd) begin
        rdata_q <= rd_mux;
        if (hit_data) rd_idx_q <= rd_idx_q + 2'd1;
      end
    end
  end

  assign stage_sec = {stage_q[3], stage_q[2]};
  assign stage_ns  = {stage_q[1][13:0], stage_q[0]};
  assign rate_mag  = {trim_hi_q[HI_BITS-1:0], trim_lo_q};
  assign rate_neg  = trim_hi_q[TRIM_DIR_BIT];
  assign wr_idx    = wr_idx_q;
  assign bus_rdata = rdata_q;

endmodule

// File: rtl/ptod_trim.sv
module ptod_trim #(
  parameter int FRAC_W  = 32,
  parameter int RATE_W  = 26,
  parameter int NOM_INC = 8,
  parameter int INC_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [RATE_W-1:0] rate_mag,
  input  logic              rate_neg,
  output logic [INC_W-1:0]  inc
);

  localparam logic [INC_W-1:0] INC_NOM  = INC_W'(NOM_INC);
  localparam logic [INC_W-1:0] INC_SLOW = INC_W'(NOM_INC - 1);
  localparam logic [INC_W-1:0] INC_FAST = INC_W'(NOM_INC + 1);

  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;

  assign sum = {1'b0, acc_q} + {{(FRAC_W + 1 - RATE_W){1'b0}}, rate_mag};

  always_comb begin
    if (!sum[FRAC_W]) inc = INC_NOM;
    else if (rate_neg) inc = INC_SLOW;
    else inc = INC_FAST;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   acc_q <= '0;
    else if (run) acc_q <= sum[FRAC_W-1:0];
  end

endmodule

// File: rtl/ptod_counter.sv
module ptod_counter
  import ptod_pkg::*;
#(
  parameter int INC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_t             cmd,
  input  logic [31:0]      stage_sec,
  input  logic [29:0]      stage_ns,
  input  logic [INC_W-1:0] inc,
  output logic             run,
  output logic [31:0]      sec,
  output logic [29:0]      ns
);

  logic        run_q, run_d;
  logic [31:0] sec_q, sec_d, st_sec, step_sec;
  logic [29:0] ns_q, ns_d;
  ns_fold_t    st, t_tick, t_step;

  always_comb begin
    st       = fold_ns({2'b00, stage_ns});
    st_sec   = stage_sec + 32'(st.carry);
    t_tick   = fold_ns({2'b00, ns_q} + (run_q ? {{(32 - INC_W){1'b0}}, inc} : 32'd0));
    t_step   = fold_ns({2'b00, t_tick.ns} + (cmd.step ? {2'b00, st.ns} : 32'd0));
    step_sec = cmd.step ? st_sec : 32'd0;
    if (cmd.load) begin
      sec_d = st_sec;
      ns_d  = st.ns;
    end else begin
      sec_d = sec_q + step_sec + 32'(t_tick.carry) + 32'(t_step.carry);
      ns_d  = t_step.ns;
    end
    if (cmd.stop)       run_d = 1'b0;
    else if (cmd.start) run_d = 1'b1;
    else                run_d = run_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      sec_q <= '0;
      ns_q  <= '0;
    end else begin
      run_q <= run_d;
      sec_q <= sec_d;
      ns_q  <= ns_d;
    end
  end

  assign run = run_q;
  assign sec = sec_q;
  assign ns  = ns_q;

endmodule

// File: rtl/ptod_clock.sv
module ptod_clock
  import ptod_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int BANK_W   = 3,
  parameter int CLK_BANK = 4,
  parameter int RATE_W   = 26,
  parameter int FRAC_W   = 32,
  parameter int NOM_INC  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic [31:0]       tod_sec,
  output logic [29:0]       tod_ns,
  output logic              tod_running
);

  localparam int INC_W = $clog2(NOM_INC + 2);

  cmd_t              cmd_w;
  logic [31:0]       stage_sec_w;
  logic [29:0]       stage_ns_w;
  logic [RATE_W-1:0] rate_mag_w;
  logic              rate_neg_w;
  logic [1:0]        wr_idx_w;
  logic [INC_W-1:0]  inc_w;

  ptod_regif #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .CLK_BANK(CLK_BANK), .RATE_W(RATE_W)
  ) u_regif (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .cur_sec(tod_sec), .cur_ns(tod_ns),
    .cmd(cmd_w), .stage_sec(stage_sec_w), .stage_ns(stage_ns_w),
    .rate_mag(rate_mag_w), .rate_neg(rate_neg_w), .wr_idx(wr_idx_w),
    .bus_rdata(bus_rdata)
  );

  ptod_trim #(
    .FRAC_W(FRAC_W), .RATE_W(RATE_W), .NOM_INC(NOM_INC), .INC_W(INC_W)
  ) u_trim (
    .clk(clk), .rst_n(rst_n), .run(tod_running),
    .rate_mag(rate_mag_w), .rate_neg(rate_neg_w), .inc(inc_w)
  );

  ptod_counter #(.INC_W(INC_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .cmd(cmd_w),
    .stage_sec(stage_sec_w), .stage_ns(stage_ns_w), .inc(inc_w),
    .run(tod_running), .sec(tod_sec), .ns(tod_ns)
  );

endmodule

// File: rtl/ptod_clock_chk.sv
module ptod_clock_chk
  import ptod_pkg::*;
#(
  parameter int NOM_INC = 8,
  parameter int RATE_W  = 26,
  parameter int INC_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input cmd_t              cmd_w,
  input logic [31:0]       stage_sec_w,
  input logic [29:0]       stage_ns_w,
  input logic [RATE_W-1:0] rate_mag_w,
  input logic              rate_neg_w,
  input logic [INC_W-1:0]  inc_w,
  input logic [1:0]        wr_idx_w,
  input logic [31:0]       tod_sec,
  input logic [29:0]       tod_ns,
  input logic              tod_running
);

  // R5
  ns_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tod_ns < 30'(NS_PER_SEC));

  // R5
  sec_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tod_running && !cmd_w.load && !cmd_w.step)
    |=> (tod_ns > $past(tod_ns)) || (tod_sec == $past(tod_sec) + 32'd1));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tod_running && !cmd_w.load && !cmd_w.step)
    |=> $stable(tod_sec) && $stable(tod_ns));

  // R3
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w.load && stage_ns_w < 30'(NS_PER_SEC))
    |=> tod_sec == $past(stage_sec_w) && tod_ns == $past(stage_ns_w));

  // R8
  zero_trim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_mag_w == '0) |-> inc_w == INC_W'(NOM_INC));

  // R8
  trim_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rate_neg_w |-> inc_w <= INC_W'(NOM_INC));

  // R9
  idx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_w != '0) |=> wr_idx_w == 2'd0);

endmodule

bind ptod_clock ptod_clock_chk #(
  .NOM_INC(NOM_INC), .RATE_W(RATE_W), .INC_W(INC_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_w(cmd_w),
  .stage_sec_w(stage_sec_w), .stage_ns_w(stage_ns_w),
  .rate_mag_w(rate_mag_w), .rate_neg_w(rate_neg_w), .inc_w(inc_w),
  .wr_idx_w(wr_idx_w), .tod_sec(tod_sec), .tod_ns(tod_ns),
  .tod_running(tod_running)
);

// File: tb/ptod_clock_bench.sv
module ptod_clock_bench;
  import ptod_pkg::*;

  localparam int     CLK_PERIOD = 10;
  localparam int     NOM        = 8;
  localparam longint BILLION    = 64'd1_000_000_000;
  localparam longint TWO32      = 64'h1_0000_0000;
  localparam logic [15:0] C_START = 16'h0001, C_STOP = 16'h0002, C_LOAD = 16'h0004,
                          C_STEP  = 16'h0008, C_SNAP = 16'h0010;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [31:0] tod_sec;
  logic [29:0] tod_ns;
  logic        tod_running;

  ptod_clock #(.NOM_INC(NOM)) u_ptod_clock (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tod_sec(tod_sec), .tod_ns(tod_ns), .tod_running(tod_running)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0, n_bad = 0;

  // ---------------- reference model in total nanoseconds ----------------
  longint      m_t, m_latch, m_acc;
  bit          m_run, m_neg;
  int          m_bank, m_wi;
  logic [15:0] m_st [4];
  logic [15:0] m_hi, m_lo;

  function automatic longint staged_total(input logic [15:0] w0, w1, w2, w3, input bit signed_sec);
    longint s;
    s = signed_sec ? longint'($signed({w3, w2})) : longint'({w3, w2});
    return s * BILLION + longint'({w1[13:0], w0});
  endfunction

  always @(posedge clk) begin
    int     inc;
    bit     cw;
    longint pre;
    if (!rst_n) begin
      m_t = 0; m_latch = 0; m_acc = 0; m_run = 0; m_neg = 0;
      m_bank = 0; m_wi = 0; m_hi = 0; m_lo = 0;
      for (int i = 0; i < 4; i++) m_st[i] = 0;
    end else begin
      inc = NOM;
      pre = m_t;
      if (m_run) begin
        m_acc += longint'({m_hi[9:0], m_lo});
        if (m_acc >= TWO32) begin
          m_acc -= TWO32;
          inc = m_neg ? NOM - 1 : NOM + 1;
        end
      end
      cw = bus_wr && m_bank == 4 && bus_addr == 5'(A_CMD);
      if (cw && bus_wdata[CB_SNAP]) m_latch = pre;
      if (cw && bus_wdata[CB_LOAD]) m_t = staged_total(m_st[0], m_st[1], m_st[2], m_st[3], 1'b0);
      else begin
        if (m_run) m_t += inc;
        if (cw && bus_wdata[CB_STEP]) m_t += staged_total(m_st[0], m_st[1], m_st[2], m_st[3], 1'b1);
      end
      if (cw) begin
        if (bus_wdata[CB_STOP]) m_run = 0;
        else if (bus_wdata[CB_START]) m_run = 1;
        m_wi = 0;
      end
      if (bus_wr && m_bank == 4 && bus_addr == 5'(A_TDATA)) begin
        m_st[m_wi] = bus_wdata;
        m_wi = (m_wi + 1) % 4;
      end
      if (bus_wr && m_bank == 4 && bus_addr == 5'(A_TRIMHI)) begin
        m_hi = bus_wdata & 16'h83FF;
        m_neg = bus_wdata[15];
      end
      if (bus_wr && m_bank == 4 && bus_addr == 5'(A_TRIMLO)) m_lo = bus_wdata;
      if (bus_wr && bus_addr == 5'(A_BANK)) m_bank = int'(bus_wdata[2:0]);
    end
  end

  // ---------------- helpers ----------------
  function automatic longint tod_total();
    return longint'({32'd0, tod_sec}) * BILLION + longint'({34'd0, tod_ns});
  endfunction

  function automatic logic [15:0] word_of(input longint t, input int idx);
    logic [31:0] s;
    logic [29:0] n;
    s = 32'(t / BILLION);
    n = 30'(t % BILLION);
    case (idx)
      0:       return n[15:0];
      1:       return {2'b00, n[29:16]};
      2:       return s[15:0];
      default: return s[31:16];
    endcase
  endfunction

  function automatic longint ppb_to_trim(input longint ppb);
    return (ppb << 26) / 64'd1953125;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_time(input string req, input longint exp_t);
    check(tod_total() == exp_t, req, tod_total(), exp_t);
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = 5'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    bus_rd = 1'b1; bus_addr = 5'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic stage(input logic [31:0] s, input logic [29:0] n, input logic [1:0] junk);
    wr(A_TDATA, n[15:0]);
    wr(A_TDATA, {junk, n[29:16]});
    wr(A_TDATA, s[15:0]);
    wr(A_TDATA, s[31:16]);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] d;
    longint t0, tr;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_time("R1 reset time", 0);
    check(tod_running == 1'b0, "R1 stopped", tod_running, 0);
    check(bus_rdata == 16'd0, "R1 rdata", bus_rdata, 0);
    rd(A_BANK, d);
    check(d == 16'd0, "R1 bank", d, 0);

    // R2 clock registers ignored outside bank 4
    stage(32'd5, 30'd77, 2'b00);
    wr(A_CMD, C_LOAD | C_START);
    @(negedge clk);
    chk_time("R2 load off bank", 0);
    check(tod_running == 1'b0, "R2 start off bank", tod_running, 0);
    wr(A_BANK, 16'd4);
    rd(A_BANK, d);
    check(d == 16'd4, "R2 bank readback", d, 4);
    wr(A_TRIMHI, 16'h0001);
    wr(A_BANK, 16'd0);
    rd(A_TRIMHI, d);
    check(d == 16'd0, "R2 read off bank", d, 0);
    wr(A_TRIMHI, 16'h03FF);
    wr(A_BANK, 16'd4);
    rd(A_TRIMHI, d);
    check(d == 16'h0001, "R2 write off bank", d, 1);
    wr(A_TRIMHI, 16'h0000);

    // R3 staging order and load, bits 15:14 of word 1 ignored
    stage(32'h0001_2345, 30'd123_456_789, 2'b11);
    wr(A_CMD, C_LOAD);
    chk_time("R3 load", 64'h12345 * BILLION + 123_456_789);

    // R4 start, nominal ticking, stop edge still ticks
    t0 = tod_total();
    wr(A_CMD, C_START);
    chk_time("R4 start edge no tick", t0);
    @(negedge clk);
    chk_time("R4 first tick", t0 + NOM);
    repeat (9) @(negedge clk);
    chk_time("R4 ten ticks", t0 + 10 * NOM);
    wr(A_CMD, C_STOP | C_START);
    chk_time("R4 stop edge ticks", t0 + 11 * NOM);
    repeat (5) @(negedge clk);
    chk_time("R4 stopped holds", t0 + 11 * NOM);
    check(tod_running == 1'b0, "R4 stop wins", tod_running, 0);

    // R5 wrap into seconds while running
    wr(A_CMD, C_START);
    stage(32'd7, 30'd999_999_996, 2'b00);
    wr(A_CMD, C_LOAD | C_STEP);
    check(tod_sec == 32'd7 && tod_ns == 30'd999_999_996, "R5 load over step", tod_total(), 7 * BILLION + 999_999_996);
    @(negedge clk);
    check(tod_sec == 32'd8, "R5 sec carry", tod_sec, 8);
    check(tod_ns == 30'd4, "R5 ns wrap", tod_ns, 4);

    // R6 positive step with the tick of the same edge
    stage(32'd3, 30'd999_999_995, 2'b00);
    t0 = tod_total();
    wr(A_CMD, C_STEP);
    chk_time("R6 positive step", t0 + NOM + 3 * BILLION + 999_999_995);
    // R6 negative step with borrow
    stage(32'd20, 30'd1, 2'b00);
    wr(A_CMD, C_LOAD);
    stage(32'hFFFF_FFFF, 30'd999_999_950, 2'b00);
    t0 = tod_total();
    wr(A_CMD, C_STEP);
    chk_time("R6 negative step", t0 + NOM - 50);
    check(tod_sec == 32'd19, "R6 borrow", tod_sec, 19);

    // R7 snapshot and four-word readback
    repeat (3) @(negedge clk);
    t0 = tod_total();
    wr(A_CMD, C_SNAP);
    for (int i = 0; i < 4; i++) begin
      rd(A_TDATA, d);
      check(d == word_of(t0, i), "R7 snapshot word", d, word_of(t0, i));
    end
    check(word_of(t0, 1) < 16'h4000, "R7 word1 top bits", word_of(t0, 1), 0);

    // R9 partial sequence discarded by a bare command write
    wr(A_CMD, C_STOP);
    wr(A_TDATA, 16'hDEAD);
    wr(A_TDATA, 16'hBEEF);
    wr(A_CMD, 16'h0000);
    stage(32'd55, 30'd777, 2'b00);
    wr(A_CMD, C_LOAD);
    chk_time("R9 index reset", 55 * BILLION + 777);

    // R10 over-range staged nanoseconds
    stage(32'd9, 30'd1_050_000_000, 2'b00);
    wr(A_CMD, C_LOAD);
    check(tod_sec == 32'd10 && tod_ns == 30'd50_000_000, "R10 fold", tod_total(), 10 * BILLION + 50_000_000);

    // R8 positive trim, closed form from a zero accumulator
    tr = ppb_to_trim(1_953_124);
    stage(32'd0, 30'd0, 2'b00);
    wr(A_CMD, C_LOAD);
    wr(A_TRIMHI, 16'h7C00 | 16'(tr >> 16));
    wr(A_TRIMLO, 16'(tr));
    rd(A_TRIMHI, d);
    check(d == 16'(tr >> 16), "R8 trim-high mask", d, tr >> 16);
    wr(A_CMD, C_START);
    repeat (1000) @(negedge clk);
    chk_time("R8 fast trim", 1000 * NOM + (1000 * tr) / TWO32);
    // R8 negative trim against the model
    wr(A_TRIMHI, 16'h8000 | 16'(tr >> 16));
    repeat (700) @(negedge clk);
    chk_time("R8 slow trim", m_t);
    check(tod_total() < 1000 * NOM + 701 * NOM + 20, "R8 slow bound", tod_total(), 1701 * NOM);

    // random phase: tick, trim carry, step and snapshot overlap
    for (int it = 0; it < 400; it++) begin
      int op;
      op = int'($urandom_range(0, 5));
      case (op)
        0: begin
          stage(32'($urandom_range(2000, 1 << 20)), 30'($urandom_range(0, (1 << 30) - 1)), 2'($urandom));
          wr(A_CMD, C_LOAD | 16'($urandom_range(0, 1)));
          chk_time("R3 random load", m_t);
        end
        1: begin
          if (m_t > 10 * BILLION)
            stage(32'($signed(int'($urandom_range(0, 6)) - 3)), 30'($urandom_range(0, 999_999_999)), 2'b00);
          else
            stage(32'($urandom_range(0, 3)), 30'($urandom_range(0, 999_999_999)), 2'b00);
          wr(A_CMD, C_STEP | (16'($urandom_range(0, 1)) << CB_SNAP));
          chk_time("R6 random step", m_t);
        end
        2: begin
          wr(A_CMD, 16'($urandom_range(0, 3)));
          chk_time("R4 random start/stop", m_t);
        end
        3: begin
          wr(A_TRIMHI, 16'($urandom));
          wr(A_TRIMLO, 16'($urandom));
          chk_time("R8 random trim", m_t);
        end
        4: begin
          repeat ($urandom_range(1, 20)) @(negedge clk);
          chk_time("R5 random run", m_t);
        end
        default: begin
          wr(A_CMD, C_SNAP);
          t0 = m_latch;
          for (int i = 0; i < 4; i++) begin
            rd(A_TDATA, d);
            check(d == word_of(t0, i), "R7 random snapshot", d, word_of(t0, i));
          end
        end
      endcase
    end

    summary();
    $finish;
  end

endmodule